// File: doc/BRIEF.md
# PWM Period and Prescaler Resolver

This block sits in front of a pulse-width core whose counter period is shared by every channel. Each request names one channel and gives a period and a pulse width, both in base-clock cycles, plus an invert flag. From these the resolver works out three things:

- the prescaler and counter top the core needs, and whether they must be rewritten;
- the 16-bit compare word for that channel;
- whether the core has to be started (reloaded) or stopped.

A request is rejected when it names a channel that does not exist. It is also rejected when it would move the shared period while some other channel is still producing pulses. A duty cycle of 0% or 100% needs no counter at all. Such a channel is treated as a constant level and reported on a level output.

Firmware or a sequencer presents one request at a time while `busy` is low. The block then emits one or more write strobes toward the core and finishes with a single-cycle `done` carrying the accept flag. After the core has been told to stop, a later start is held back until the core signals that it has actually stopped.

Top module: `pwm_period_resolver`

## Requirements
- R1: A request whose channel index is NUM_CH or above is rejected (`done` with `accepted`=0). It produces no configuration, compare, level, start or stop strobe.
- R2: When `center_mode` is 1, the requested period and pulse are each divided by two (shift right by one) before every other rule below is applied.
- R3: A pulse of 0 gives compare magnitude (bits 14:0) 0. A nonzero pulse at or above the period gives magnitude 0x7FFF. Both clear the channel's needed bit and are accepted. Both raise `lvl_write`, with `lvl_value` = 1 for the full pulse and 0 for the zero pulse, XOR the invert flag.
- R4: Bit 15 of every compare word is 1 when the invert flag is 0, and 0 when the invert flag is 1.
- R5: For any other pulse, a period equal to the one currently configured is accepted without a `cfg_write`. Its magnitude is the pulse shifted right by the configured prescaler.
- R6: For any other pulse with a different period, the request is rejected if any channel other than the requesting one currently has its needed bit set.
- R7: Otherwise the prescaler is the smallest p in 0..7 with (period >> p) <= 0x7FFF. The block raises `cfg_write` with `cfg_prescaler`=p and `cfg_top`=period>>p, and the magnitude is pulse>>p. If no such p exists, the request is rejected and the configuration is unchanged.
- R8: On every accepted request, `core_stop` pulses with `done` when no channel's needed bit remains set. Otherwise `core_start` pulses with `done`.
- R9: After a `core_stop`, no `core_start` is issued before a `core_stopped` pulse has been received.
- R10: `done` is high for exactly one cycle per request. Requests are taken only while `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| center_mode | input | 1 | 1 = core counts up and down, so inputs are halved |
| req_valid | input | 1 | Request strobe, sampled while busy is 0 |
| req_chan | input | CH_IN_W | Requested channel index |
| req_period | input | PERIOD_W | Period in base-clock cycles |
| req_pulse | input | PERIOD_W | Pulse width in base-clock cycles |
| req_invert | input | 1 | Invert output polarity |
| core_stopped | input | 1 | Core reports that it has halted |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle end-of-request pulse |
| accepted | output | 1 | Status qualifying done |
| cfg_write | output | 1 | Write strobe for prescaler and top |
| cfg_prescaler | output | PRESC_W | Prescaler exponent |
| cfg_top | output | TOP_W | Counter top |
| cmp_write | output | 1 | Compare word write strobe |
| cmp_chan | output | CH_W | Channel for compare and level writes |
| cmp_word | output | TOP_W+1 | Polarity bit and compare magnitude |
| lvl_write | output | 1 | Constant-level strobe |
| lvl_value | output | 1 | Constant output level |
| core_start | output | 1 | Start or reload command |
| core_stop | output | 1 | Stop command |

## Verification
A directed sequence first walks through the pattern that builds up and then drains the needed mask:

- a first channel sets the period;
- a second channel asks for a conflicting period and is refused, then matches the period and is accepted;
- both channels go to constant levels;
- a large period forces a nonzero prescaler, and its start must wait for the stopped pulse;
- a period too long for any prescaler is refused.

Seeded random requests follow. They mix a small set of periods, so that matches, conflicts and period changes all recur. The pulses include zero, over-period values and in-range widths, and one channel index out of range appears. Half of this traffic runs in center mode, which separates a correct halving from a halving applied to only one operand. Every strobe value is compared with a model of the shared-period state kept in the bench.

// File: rtl/pwmr_pkg.sv
// Package: shared types and helpers for the period resolver.
// Assumes a compare word of one polarity bit above the magnitude field.
package pwmr_pkg;

    typedef enum logic [1:0] {
        RS_IDLE,
        RS_EVAL,
        RS_CMD,
        RS_WAIT
    } rs_state_e;

    // Build a compare word: the polarity bit is the complement of the invert flag.
    function automatic logic [15:0] pack_word(input logic inv, input logic [14:0] mag);
        return {~inv, mag};
    endfunction

endpackage

// File: rtl/pwmr_presc_search.sv
// Module: pwmr_presc_search
// Finds the smallest prescaler exponent for which the shifted period fits
// the counter-top field. Purely combinational; the caller registers results.
module pwmr_presc_search #(
    parameter int PERIOD_W = 32,
    parameter int TOP_W    = 15,
    parameter int PRESC_W  = 3
) (
    input  logic [PERIOD_W-1:0] period,
    output logic                found,
    output logic [PRESC_W-1:0]  presc,
    output logic [TOP_W-1:0]    top
);
    localparam int NUM_P = 1 << PRESC_W;
    localparam logic [PERIOD_W-1:0] MAX_TOP = PERIOD_W'((64'd1 << TOP_W) - 64'd1);

    logic [NUM_P-1:0] fits;

    // One fit test per candidate exponent.
    genvar gp;
    generate
        for (gp = 0; gp < NUM_P; gp++) begin : g_cand
            assign fits[gp] = (period >> gp) <= MAX_TOP;
        end
    endgenerate

    // Priority pick of the lowest exponent that fits.
    always_comb begin
        found = 1'b0;
        presc = '0;
        for (int i = NUM_P - 1; i >= 0; i--) begin
            if (fits[i]) begin
                found = 1'b1;
                presc = PRESC_W'(i);
            end
        end
    end

    // Counter top for the chosen exponent.
    always_comb top = TOP_W'(period >> presc);

endmodule

// File: rtl/pwmr_need_mask.sv
// Module: pwmr_need_mask
// Holds one bit per channel that is set while the channel needs active
// generation. Also reports whether any channel other than the given one is set.
module pwmr_need_mask #(
    parameter int NUM_CH = 4,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd,
    input  logic [CH_W-1:0]   chan,
    input  logic              set_val,
    output logic [NUM_CH-1:0] mask,
    output logic              others_busy
);
    logic [NUM_CH-1:0] sel;

    // Decode the addressed channel.
    always_comb sel = NUM_CH'(1) << chan;

    // Update the addressed bit on request.
    always_ff @(posedge clk) begin
        if (!rst_n)   mask <= '0;
        else if (upd) mask <= set_val ? (mask | sel) : (mask & ~sel);
    end

    // Any needed channel besides the addressed one.
    always_comb others_busy = |(mask & ~sel);

endmodule

// File: rtl/pwm_period_resolver.sv
// Module: pwm_period_resolver
// Turns per-channel period/pulse requests into configuration, compare and
// start/stop commands for a PWM core with one shared period.
// Assumes one request at a time, taken while busy is low; core_stopped is a
// single-cycle event from the core.
module pwm_period_resolver #(
    parameter int NUM_CH   = 4,
    parameter int PERIOD_W = 32,
    parameter int TOP_W    = 15,
    parameter int PRESC_W  = 3,
    localparam int CH_W    = $clog2(NUM_CH),
    localparam int CH_IN_W = CH_W + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                center_mode,
    input  logic                req_valid,
    input  logic [CH_IN_W-1:0]  req_chan,
    input  logic [PERIOD_W-1:0] req_period,
    input  logic [PERIOD_W-1:0] req_pulse,
    input  logic                req_invert,
    input  logic                core_stopped,
    output logic                busy,
    output logic                done,
    output logic                accepted,
    output logic                cfg_write,
    output logic [PRESC_W-1:0]  cfg_prescaler,
    output logic [TOP_W-1:0]    cfg_top,
    output logic                cmp_write,
    output logic [CH_W-1:0]     cmp_chan,
    output logic [TOP_W:0]      cmp_word,
    output logic                lvl_write,
    output logic                lvl_value,
    output logic                core_start,
    output logic                core_stop
);
    import pwmr_pkg::*;

    localparam logic [TOP_W-1:0] FULL_MAG = '1;

    rs_state_e             state;
    logic [CH_IN_W-1:0]    r_chan;
    logic [PERIOD_W-1:0]   r_period, r_pulse, cur_period;
    logic                  r_inv, stop_pend;
    logic [PRESC_W-1:0]    cur_presc;

    logic                  chan_ok, is_zero, is_full, is_const, same_per;
    logic                  s_found, others_busy, mask_upd;
    logic [PRESC_W-1:0]    s_presc;
    logic [TOP_W-1:0]      s_top;
    logic [NUM_CH-1:0]     need_mask;

    // Classify the captured request.
    always_comb begin
        chan_ok  = r_chan < CH_IN_W'(NUM_CH);
        is_zero  = r_pulse == '0;
        is_full  = !is_zero && (r_pulse >= r_period);
        is_const = is_zero || is_full;
        same_per = r_period == cur_period;
    end

    pwmr_presc_search #(
        .PERIOD_W(PERIOD_W), .TOP_W(TOP_W), .PRESC_W(PRESC_W)
    ) u_search (
        .period(r_period), .found(s_found), .presc(s_presc), .top(s_top)
    );

    // The mask changes only on an accepted evaluation.
    always_comb mask_upd = (state == RS_EVAL) && chan_ok &&
                           (is_const || same_per || (!others_busy && s_found));

    pwmr_need_mask #(.NUM_CH(NUM_CH)) u_mask (
        .clk(clk), .rst_n(rst_n), .upd(mask_upd),
        .chan(r_chan[CH_W-1:0]), .set_val(!is_const),
        .mask(need_mask), .others_busy(others_busy)
    );

    // Busy whenever a request is in flight.
    always_comb busy = state != RS_IDLE;

    // Request sequencer: capture, evaluate, command, optional wait for stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state         <= RS_IDLE;
            r_chan        <= '0;
            r_period      <= '0;
            r_pulse       <= '0;
            r_inv         <= 1'b0;
            cur_period    <= '0;
            cur_presc     <= '0;
            stop_pend     <= 1'b0;
            done          <= 1'b0;
            accepted      <= 1'b0;
            cfg_write     <= 1'b0;
            cfg_prescaler <= '0;
            cfg_top       <= '0;
            cmp_write     <= 1'b0;
            cmp_chan      <= '0;
            cmp_word      <= '0;
            lvl_write     <= 1'b0;
            lvl_value     <= 1'b0;
            core_start    <= 1'b0;
            core_stop     <= 1'b0;
        end else begin
            done       <= 1'b0;
            cfg_write  <= 1'b0;
            cmp_write  <= 1'b0;
            lvl_write  <= 1'b0;
            core_start <= 1'b0;
            core_stop  <= 1'b0;
            if (core_stopped) stop_pend <= 1'b0;
            case (state)
                RS_IDLE: begin
                    if (req_valid) begin
                        r_chan   <= req_chan;
                        r_period <= center_mode ? (req_period >> 1) : req_period;
                        r_pulse  <= center_mode ? (req_pulse >> 1) : req_pulse;
                        r_inv    <= req_invert;
                        state    <= RS_EVAL;
                    end
                end
                RS_EVAL: begin
                    cmp_chan <= r_chan[CH_W-1:0];
                    if (!chan_ok) begin
                        done     <= 1'b1;
                        accepted <= 1'b0;
                        state    <= RS_IDLE;
                    end else if (is_const) begin
                        cmp_write <= 1'b1;
                        cmp_word  <= pack_word(r_inv, is_full ? FULL_MAG : '0);
                        lvl_write <= 1'b1;
                        lvl_value <= is_full ^ r_inv;
                        state     <= RS_CMD;
                    end else if (same_per) begin
                        cmp_write <= 1'b1;
                        cmp_word  <= pack_word(r_inv, TOP_W'(r_pulse >> cur_presc));
                        state     <= RS_CMD;
                    end else if (others_busy || !s_found) begin
                        done     <= 1'b1;
                        accepted <= 1'b0;
                        state    <= RS_IDLE;
                    end else begin
                        cfg_write     <= 1'b1;
                        cfg_prescaler <= s_presc;
                        cfg_top       <= s_top;
                        cur_period    <= r_period;
                        cur_presc     <= s_presc;
                        cmp_write     <= 1'b1;
                        cmp_word      <= pack_word(r_inv, TOP_W'(r_pulse >> s_presc));
                        state         <= RS_CMD;
                    end
                end
                RS_CMD: begin
                    if (need_mask == '0) begin
                        core_stop <= 1'b1;
                        stop_pend <= 1'b1;
                        done      <= 1'b1;
                        accepted  <= 1'b1;
                        state     <= RS_IDLE;
                    end else if (stop_pend && !core_stopped) begin
                        state <= RS_WAIT;
                    end else begin
                        core_start <= 1'b1;
                        done       <= 1'b1;
                        accepted   <= 1'b1;
                        state      <= RS_IDLE;
                    end
                end
                RS_WAIT: begin
                    if (core_stopped) begin
                        core_start <= 1'b1;
                        done       <= 1'b1;
                        accepted   <= 1'b1;
                        state      <= RS_IDLE;
                    end
                end
                default: state <= RS_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/pwmr_checker.sv
// Module: pwmr_checker
// Temporal checks on the resolver ports; attached to every instance by bind.
module pwmr_checker #(
    parameter int NUM_CH = 4,
    parameter int TOP_W  = 15,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            done,
    input logic            accepted,
    input logic            cfg_write,
    input logic            cmp_write,
    input logic            lvl_write,
    input logic [TOP_W:0]  cmp_word,
    input logic            core_start,
    input logic            core_stop,
    input logic            core_stopped
);
    logic stop_seen;

    // Track a stop that the core has not yet acknowledged.
    always_ff @(posedge clk) begin
        if (!rst_n)            stop_seen <= 1'b0;
        else if (core_stop)    stop_seen <= 1'b1;
        else if (core_stopped) stop_seen <= 1'b0;
    end

    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_start_stop_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(core_start && core_stop));

    assert_cmd_with_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (core_start || core_stop) |-> (done && accepted));

    assert_reject_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !accepted) |-> (!core_start && !core_stop && !cmp_write && !cfg_write));

    assert_cfg_with_cmp_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_write |-> cmp_write);

    assert_level_magnitude_R3: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_write |-> (cmp_write && ((cmp_word[TOP_W-1:0] == '0) || (&cmp_word[TOP_W-1:0]))));

    assert_no_early_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        core_start |-> !stop_seen);

endmodule

bind pwm_period_resolver pwmr_checker #(.NUM_CH(NUM_CH), .TOP_W(TOP_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .done(done), .accepted(accepted),
    .cfg_write(cfg_write), .cmp_write(cmp_write), .lvl_write(lvl_write),
    .cmp_word(cmp_word), .core_start(core_start), .core_stop(core_stop),
    .core_stopped(core_stopped)
);

// File: tb/sim_pwm_period_resolver.sv
// Bench for pwm_period_resolver: directed corner cases then seeded random
// requests, every strobe compared against a model of the shared-period state.
module sim_pwm_period_resolver;
    localparam int NUM_CH = 4;
    localparam int PW     = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        center_mode = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_chan = '0;
    logic [31:0] req_period = '0;
    logic [31:0] req_pulse = '0;
    logic        req_invert = 1'b0;
    logic        core_stopped = 1'b0;
    logic        busy, done, accepted, cfg_write, cmp_write, lvl_write, lvl_value;
    logic        core_start, core_stop;
    logic [2:0]  cfg_prescaler;
    logic [14:0] cfg_top;
    logic [1:0]  cmp_chan;
    logic [15:0] cmp_word;

    int n_chk = 0, n_fail = 0, cyc = 0, deferred = 0;
    logic outstanding = 1'b0;
    int   stop_cnt = 0;

    // model state
    logic [31:0] m_period = '0;
    logic [2:0]  m_presc = '0;
    logic [3:0]  m_mask = '0;

    always #5 clk = ~clk;

    pwm_period_resolver u0 (
        .clk(clk), .rst_n(rst_n), .center_mode(center_mode), .req_valid(req_valid),
        .req_chan(req_chan), .req_period(req_period), .req_pulse(req_pulse),
        .req_invert(req_invert), .core_stopped(core_stopped), .busy(busy),
        .done(done), .accepted(accepted), .cfg_write(cfg_write),
        .cfg_prescaler(cfg_prescaler), .cfg_top(cfg_top), .cmp_write(cmp_write),
        .cmp_chan(cmp_chan), .cmp_word(cmp_word), .lvl_write(lvl_write),
        .lvl_value(lvl_value), .core_start(core_start), .core_stop(core_stop)
    );

    task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Core stand-in: acknowledges a stop some cycles later; checks R9.
    always @(negedge clk) begin
        cyc++;
        if (core_stopped) core_stopped <= 1'b0;
        if (rst_n && core_start)
            chk(!outstanding, "R9 start while stop unacknowledged", 1, 0);
        if (rst_n && core_stop) begin
            outstanding = 1'b1;
            stop_cnt    = 6;
        end else if (stop_cnt > 0) begin
            stop_cnt--;
            if (stop_cnt == 0) begin
                core_stopped <= 1'b1;
                outstanding = 1'b0;
            end
        end
    end

    // Watchdog.
    initial begin
        wait (cyc > 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    task automatic do_req(input int ch, input logic [31:0] per, input logic [31:0] pul,
                          input logic inv);
        logic [31:0] hp, hu;
        logic e_acc, e_cfg, e_cmp, e_lvl, e_lv, e_start, e_stop, cst, full;
        logic [2:0]  e_p;
        logic [14:0] e_top, e_mag;
        string       rtag;
        logic s_cfg, s_cmp, s_lvl, s_lv, s_start, s_stop, s_done, s_acc, was_out;
        logic [2:0]  s_p; logic [14:0] s_top; logic [15:0] s_word; logic [1:0] s_ch;
        int waitc;
        // expected from requirements
        hp = center_mode ? per >> 1 : per;
        hu = center_mode ? pul >> 1 : pul;
        e_cfg = 0; e_cmp = 0; e_lvl = 0; e_lv = 0; e_start = 0; e_stop = 0;
        e_p = 0; e_top = 0; e_mag = 0;
        full = (hu != 0) && (hu >= hp);
        cst  = (hu == 0) || full;
        if (ch >= NUM_CH) begin e_acc = 0; rtag = "R1"; end
        else if (cst) begin
            e_acc = 1; e_cmp = 1; e_lvl = 1; e_lv = full ^ inv;
            e_mag = full ? 15'h7FFF : 15'h0; rtag = "R3";
            m_mask[ch] = 1'b0;
        end else if (hp == m_period) begin
            e_acc = 1; e_cmp = 1; e_mag = 15'(hu >> m_presc); rtag = "R5";
            m_mask[ch] = 1'b1;
        end else if ((m_mask & ~(4'b1 << ch)) != 0) begin
            e_acc = 0; rtag = "R6";
        end else begin
            e_acc = 0; rtag = "R7";
            for (int p = 7; p >= 0; p--)
                if ((hp >> p) <= 32'h7FFF) begin e_acc = 1; e_p = 3'(p); end
            if (e_acc) begin
                e_cfg = 1; e_cmp = 1; e_top = 15'(hp >> e_p); e_mag = 15'(hu >> e_p);
                m_period = hp; m_presc = e_p; m_mask[ch] = 1'b1;
            end
        end
        if (center_mode) rtag = {rtag, " R2"};
        if (e_acc) begin e_stop = (m_mask == 0); e_start = !e_stop; end
        // drive
        was_out = outstanding;
        req_chan = 3'(ch); req_period = per; req_pulse = pul; req_invert = inv;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        s_cfg = 0; s_cmp = 0; s_lvl = 0; s_lv = 0; s_start = 0; s_stop = 0;
        s_done = 0; s_acc = 0; s_p = 0; s_top = 0; s_word = 0; s_ch = 0; waitc = 0;
        while (!s_done && waitc < 200) begin
            @(negedge clk);
            waitc++;
            if (cfg_write) begin s_cfg = 1; s_p = cfg_prescaler; s_top = cfg_top; end
            if (cmp_write) begin s_cmp = 1; s_word = cmp_word; s_ch = cmp_chan; end
            if (lvl_write) begin s_lvl = 1; s_lv = lvl_value; end
            if (core_start) s_start = 1;
            if (core_stop) s_stop = 1;
            if (done) begin s_done = 1; s_acc = accepted; end
        end
        chk(s_done, "R10 done seen", s_done, 1);
        chk(s_acc == e_acc, {rtag, " accept"}, s_acc, e_acc);
        chk(s_cmp == e_cmp, {rtag, " cmp_write"}, s_cmp, e_cmp);
        chk(s_cfg == e_cfg, {rtag, " cfg_write"}, s_cfg, e_cfg);
        chk(s_lvl == e_lvl, "R3 lvl_write", s_lvl, e_lvl);
        chk(s_start == e_start && s_stop == e_stop, "R8 start/stop",
            {s_start, s_stop}, {e_start, e_stop});
        if (e_cmp && s_cmp) begin
            chk(s_word[15] == !inv, "R4 polarity bit", s_word[15], !inv);
            chk(s_word[14:0] == e_mag, {rtag, " magnitude"}, s_word[14:0], e_mag);
            chk(s_ch == 2'(ch), {rtag, " cmp_chan"}, s_ch, ch);
        end
        if (e_cfg && s_cfg)
            chk(s_p == e_p && s_top == e_top, "R7 prescaler/top", {s_p, s_top}, {e_p, e_top});
        if (e_lvl && s_lvl) chk(s_lv == e_lv, "R3 level", s_lv, e_lv);
        if (e_start && was_out) deferred++;
        @(negedge clk);
        chk(!done && !busy, "R10 done single cycle, idle after", {done, busy}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !done && !core_start && !core_stop && !cfg_write && !cmp_write,
            "R10 reset state", {busy, done, core_start, core_stop}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // directed corners
        do_req(0, 1000, 250, 0);        // R7 p=0
        do_req(1, 2000, 5, 0);          // R6 conflict
        do_req(1, 1000, 500, 1);        // R5 same period, R4 inverted
        do_req(0, 1000, 1000, 0);       // R3 full
        do_req(1, 1000, 0, 1);          // R3 zero inverted, R8 stop
        do_req(2, 100000, 30000, 0);    // R7 p=2, R9 deferred start
        chk(deferred == 1, "R9 deferred start exercised", deferred, 1);
        do_req(4, 1000, 10, 0);         // R1 out of range
        do_req(2, 5000000, 1, 0);       // R7 no prescaler fits
        do_req(2, 40000, 100, 0);       // R6 own channel may retune
        center_mode = 1'b1;
        do_req(2, 80000, 200, 0);       // R2 halved matches
        center_mode = 1'b0;
        // seeded random
        void'($urandom(32'd1234));
        for (int i = 0; i < 300; i++) begin
            int ch, k;
            logic [31:0] per, pul;
            center_mode = (i >= 150);
            ch = int'($urandom % 5);
            k  = int'($urandom % 6);
            per = (k == 0) ? 32'd1000 : (k == 1) ? 32'd40000 : (k == 2) ? 32'd300 :
                  (k == 3) ? 32'd2000000 : (k == 4) ? 32'd9000000 : 32'd80000;
            case ($urandom % 4)
                0:       pul = 0;
                1:       pul = per + ($urandom % 3);
                default: pul = $urandom % per;
            endcase
            do_req(ch, per, pul, 1'($urandom % 2));
        end
        finish_run();
    end
endmodule